// File: doc/BRIEF.md
# Fly-By DMA Burst Sequencer

This block drives one DMA channel that moves a packet straight between a single on-chip peripheral and memory, with no staging store in between. A packet is given as a start byte address, a byte count and a direction that is fixed for the channel. Neither the address nor the count has to be word aligned. The sequencer cuts the packet into bursts of 32-bit words. For each burst it asks for the shared bus and waits for a grant. It then presents a word-aligned address, a word count and per-word byte enables, and watches the words that pass between the peripheral and the memory controller.

Each burst is one bus transaction and needs a fresh grant, so other masters can take the bus between bursts of the same packet. The peripheral may close a burst before it reaches the planned word count. The sequencer then advances the address and the remaining count by exactly the bytes that moved and asks again. When the count reaches zero it raises a one-cycle completion pulse. An abort request is taken only at a burst boundary and returns the channel to idle without that pulse.

Top module: `flyby_burst_seq`

## Requirements
- R1: After reset the sequencer is idle: `bus_req`, `busy`, `done` and `byte_en` are all 0.
- R2: While a burst is requested or running, `burst_words` equals the minimum of three values: `MAX_BURST`; `periph_max` when that is nonzero; and the number of words still touched by the packet, which is (start offset within the word + remaining bytes + 3) / 4.
- R3: Every burst, including each later burst of the same packet, starts only after a `bus_gnt` seen while `bus_req` is high. Without a grant, `bus_req` stays high and the presented burst does not change.
- R4: `burst_addr` is always the current byte address rounded down to a multiple of 4. The first burst uses the start address.
- R5: `byte_en` bit i enables the byte whose address modulo 4 is i. On the first word of the packet, lanes below the start offset are 0.
- R6: On the last word of the packet, lanes at or beyond the end of the packet are 0. Every other word in a burst has `byte_en` = 4'b1111.
- R7: When a burst ends, because its planned word count has been moved or because `burst_stop` closes it early, the address advances and the remaining count falls by the bytes actually moved. For k moved words with start offset s, that is min(4k - s, remaining), or 0 when k = 0.
- R8: A start with a byte count of 0 raises `done` in the next cycle and never raises `bus_req`.
- R9: `done` is high for exactly one cycle, in the cycle after the burst that moves the last byte. After that `busy` is 0.
- R10: An `abort` during a request or a burst returns the sequencer to idle at the next burst boundary, with `bus_req`, `busy` and `done` at 0, unless that burst finished the packet.
- R11: `xfer_dir` is a constant taken from parameter `TO_MEM` (1 = peripheral to memory). Byte counts up to 2^LEN_W - 1 are accepted with no minimum or multiple.
- R12: `start` is ignored while the sequencer is busy: the address and word count it presents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (taken only when idle) |
| start_addr | input | ADDR_W | Packet start byte address |
| byte_len | input | LEN_W | Packet length in bytes |
| abort | input | 1 | Stop at the next burst boundary |
| periph_max | input | $clog2(MAX_BURST+1) | Peripheral burst limit in words, 0 = no limit |
| bus_req | output | 1 | Bus request, held through the burst |
| bus_gnt | input | 1 | Bus grant |
| beat_valid | input | 1 | One word moved this cycle |
| burst_stop | input | 1 | Peripheral ends the burst after the words moved so far |
| burst_addr | output | ADDR_W | Word-aligned address of the burst |
| burst_words | output | $clog2(MAX_BURST+1) | Word count of the burst |
| byte_en | output | 4 | Byte lanes enabled for the current word |
| xfer_dir | output | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the sequencer with `MAX_BURST` = 4, `LEN_W` = 8 and `ADDR_W` = 16, with the peripheral limit enabled. With these values a packet of only a few bytes already needs several bursts. The bench sweeps every start offset 0 to 3 against every length from 0 to 19, so each first-word and last-word mask pattern occurs, alone and in the same word. The peripheral limit cycles through 0 to 5, so it is smaller than, equal to and larger than the burst cap. A 250-byte packet, early stops with and without moved words, an abort, and start pulses while busy cover the remaining cases.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2,
      ST_DONE = 2'd3
   } seq_state_e;

   localparam int unsigned LANES = 4;

endpackage

// File: rtl/fbs_burst_calc.sv
module fbs_burst_calc #(
   parameter int LEN_W     = 16,
   parameter int MAX_BURST = 16,
   parameter int CNT_W     = 5,
   parameter bit USE_PLIM  = 1'b1
) (
   input  logic [1:0]       off,
   input  logic [LEN_W-1:0] rem,
   input  logic [CNT_W-1:0] plim,
   output logic [LEN_W-1:0] words_left,
   output logic [CNT_W-1:0] burst_n
);
   localparam int SUM_W = LEN_W + 2;

   logic [SUM_W-1:0] span;
   logic [CNT_W-1:0] cap;

   assign span       = {2'b00, rem} + SUM_W'(off) + SUM_W'(3);
   assign words_left = span[SUM_W-1:2];

   generate
      if (USE_PLIM) begin : g_plim
         assign cap = (plim != '0 && plim < CNT_W'(MAX_BURST)) ? plim
                                                               : CNT_W'(MAX_BURST);
      end else begin : g_fixed
         assign cap = CNT_W'(MAX_BURST);
      end
   endgenerate

   assign burst_n = (words_left < LEN_W'(cap)) ? CNT_W'(words_left) : cap;

endmodule

// File: rtl/fbs_be_gen.sv
module fbs_be_gen #(
   parameter int LEN_W = 16,
   parameter int CNT_W = 5
) (
   input  logic             active,
   input  logic [1:0]       off,
   input  logic [LEN_W-1:0] rem,
   input  logic [LEN_W-1:0] words_left,
   input  logic [CNT_W-1:0] beat_idx,
   output logic [3:0]       be
);
   logic [1:0] end_off;
   logic       first_w;
   logic       last_w;
   logic [3:0] lo_mask;
   logic [3:0] hi_mask;

   assign end_off = off + rem[1:0];
   assign first_w = (beat_idx == '0);
   assign last_w  = (LEN_W'(beat_idx) == words_left - LEN_W'(1));
   assign lo_mask = 4'hF << off;
   assign hi_mask = (end_off == 2'd0) ? 4'hF : ~(4'hF << end_off);

   always_comb begin
      be = 4'h0;
      if (active) begin
         be = 4'hF;
         if (first_w) be = be & lo_mask;
         if (last_w)  be = be & hi_mask;
      end
   end

endmodule

// File: rtl/fbs_progress.sv
module fbs_progress #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LEN_W-1:0]  ld_len,
   input  logic              adv,
   input  logic [CNT_W-1:0]  words,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  rem,
   output logic [LEN_W-1:0]  rem_after
);
   localparam int RAW_W = CNT_W + 2;
   localparam int XW    = (LEN_W > RAW_W) ? LEN_W : RAW_W;

   logic [XW-1:0] raw;
   logic [XW-1:0] rem_x;
   logic [XW-1:0] moved;

   assign raw   = XW'({words, 2'b00}) - XW'(addr[1:0]);
   assign rem_x = XW'(rem);

   always_comb begin
      if (words == '0)        moved = '0;
      else if (raw < rem_x)   moved = raw;
      else                    moved = rem_x;
   end

   assign rem_after = rem - LEN_W'(moved);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         rem  <= '0;
      end else if (load) begin
         addr <= ld_addr;
         rem  <= ld_len;
      end else if (adv) begin
         addr <= addr + ADDR_W'(moved);
         rem  <= rem_after;
      end
   end

   assert_rem_descends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (rem <= $past(rem)));

endmodule

// File: rtl/flyby_burst_seq.sv
module flyby_burst_seq
   import fbs_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int MAX_BURST = 16,
   parameter bit USE_PLIM  = 1'b1,
   parameter bit TO_MEM    = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic [ADDR_W-1:0]                start_addr,
   input  logic [LEN_W-1:0]                 byte_len,
   input  logic                             abort,
   input  logic [$clog2(MAX_BURST+1)-1:0]   periph_max,
   output logic                             bus_req,
   input  logic                             bus_gnt,
   input  logic                             beat_valid,
   input  logic                             burst_stop,
   output logic [ADDR_W-1:0]                burst_addr,
   output logic [$clog2(MAX_BURST+1)-1:0]   burst_words,
   output logic [3:0]                       byte_en,
   output logic                             xfer_dir,
   output logic                             busy,
   output logic                             done
);
   localparam int CNT_W = $clog2(MAX_BURST + 1);

   initial begin
      assert (MAX_BURST >= 1) else $error("MAX_BURST must be at least 1");
      assert (LEN_W >= 3 && LEN_W > CNT_W) else $error("LEN_W too small for MAX_BURST");
      assert (ADDR_W >= LEN_W) else $error("ADDR_W must cover LEN_W");
   end

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] beat_q;
   logic [CNT_W-1:0] bw_q;
   logic             abort_q;

   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  cur_rem;
   logic [LEN_W-1:0]  rem_after;
   logic [LEN_W-1:0]  words_left;
   logic [CNT_W-1:0]  calc_n;
   logic [CNT_W-1:0]  words_moved;
   logic              in_xfer;
   logic              in_req;
   logic              load;
   logic              burst_end;

   assign in_xfer     = (state_q == ST_XFER);
   assign in_req      = (state_q == ST_REQ);
   assign load        = (state_q == ST_IDLE) && start;
   assign words_moved = beat_q + CNT_W'(beat_valid);
   assign burst_end   = in_xfer &&
                        (burst_stop || (beat_valid && beat_q == bw_q - CNT_W'(1)));

   fbs_progress #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_prog (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .ld_addr   (start_addr),
      .ld_len    (byte_len),
      .adv       (burst_end),
      .words     (words_moved),
      .addr      (cur_addr),
      .rem       (cur_rem),
      .rem_after (rem_after)
   );

   fbs_burst_calc #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .CNT_W(CNT_W),
                    .USE_PLIM(USE_PLIM)) u_calc (
      .off        (cur_addr[1:0]),
      .rem        (cur_rem),
      .plim       (periph_max),
      .words_left (words_left),
      .burst_n    (calc_n)
   );

   fbs_be_gen #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_be (
      .active     (in_xfer),
      .off        (cur_addr[1:0]),
      .rem        (cur_rem),
      .words_left (words_left),
      .beat_idx   (beat_q),
      .be         (byte_en)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = (byte_len == '0) ? ST_DONE : ST_REQ;
         ST_REQ: begin
            if (abort)        state_d = ST_IDLE;
            else if (bus_gnt) state_d = ST_XFER;
         end
         ST_XFER: begin
            if (burst_end) begin
               if (rem_after == '0)        state_d = ST_DONE;
               else if (abort_q || abort)  state_d = ST_IDLE;
               else                        state_d = ST_REQ;
            end
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         bw_q    <= '0;
         abort_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (in_req && bus_gnt) begin
            beat_q <= '0;
            bw_q   <= calc_n;
         end else if (in_xfer && beat_valid) begin
            beat_q <= words_moved;
         end
         if (state_q == ST_IDLE)   abort_q <= 1'b0;
         else if (abort)           abort_q <= 1'b1;
      end
   end

   assign bus_req     = in_req || in_xfer;
   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_DONE);
   assign burst_addr  = {cur_addr[ADDR_W-1:2], 2'b00};
   assign burst_words = in_xfer ? bw_q : calc_n;
   assign xfer_dir    = TO_MEM;

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_burst_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (burst_words != '0 && burst_words <= CNT_W'(MAX_BURST)));

   assert_grant_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_xfer) |-> $past(bus_gnt));

   assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_xfer && !burst_end) |=> $stable(burst_addr));

   assert_lane_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_xfer |-> (byte_en != 4'h0));

   assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && byte_len == '0) |=> (done && !bus_req));

endmodule

// File: tb/sim_flyby_burst_seq.sv
module sim_flyby_burst_seq;
   localparam int ADDR_W = 16;
   localparam int LEN_W  = 8;
   localparam int MAXB   = 4;
   localparam int CNT_W  = $clog2(MAXB + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic [LEN_W-1:0]  byte_len = '0;
   logic              abort = 1'b0;
   logic [CNT_W-1:0]  periph_max = '0;
   logic              bus_req;
   logic              bus_gnt = 1'b0;
   logic              beat_valid = 1'b0;
   logic              burst_stop = 1'b0;
   logic [ADDR_W-1:0] burst_addr;
   logic [CNT_W-1:0]  burst_words;
   logic [3:0]        byte_en;
   logic              xfer_dir;
   logic              busy;
   logic              done;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   flyby_burst_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAXB),
                     .USE_PLIM(1'b1), .TO_MEM(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_len(byte_len), .abort(abort), .periph_max(periph_max),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .beat_valid(beat_valid),
      .burst_stop(burst_stop), .burst_addr(burst_addr), .burst_words(burst_words),
      .byte_en(byte_en), .xfer_dir(xfer_dir), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_be(input int wa, input int ps, input int pe);
      int m = 0;
      for (int b = 0; b < 4; b++)
         if (wa + b >= ps && wa + b < pe) m |= (1 << b);
      return m;
   endfunction

   task automatic run_pkt(input int a, input int len, input int pmax, input int p,
                          input bit do_abort);
      int ra, rr, bn, off, wl, cap, ebw, nsend, bytes, hold_a, hold_w;
      bit early, zero_done;
      @(negedge clk);
      start = 1'b1; start_addr = ADDR_W'(a); byte_len = LEN_W'(len);
      periph_max = CNT_W'(pmax);
      @(negedge clk);
      start = 1'b0;
      if (len == 0) begin
         chk(done == 1'b1, "R8 done", int'(done), 1);
         chk(bus_req == 1'b0, "R8 no request", int'(bus_req), 0);
         @(negedge clk);
         chk(done == 1'b0, "R9 pulse width", int'(done), 0);
         chk(busy == 1'b0, "R9 idle after", int'(busy), 0);
         return;
      end
      ra = a; rr = len; bn = 0; zero_done = 1'b0;
      forever begin
         chk(bus_req == 1'b1, "R3 request", int'(bus_req), 1);
         off = ra % 4;
         wl  = (off + rr + 3) / 4;
         cap = (pmax != 0 && pmax < MAXB) ? pmax : MAXB;
         ebw = (wl < cap) ? wl : cap;
         chk(int'(burst_addr) == (ra & ~3), "R4 address", int'(burst_addr), ra & ~3);
         chk(int'(burst_words) == ebw, "R2 word count", int'(burst_words), ebw);
         hold_a = int'(burst_addr); hold_w = int'(burst_words);
         start = 1'b1; start_addr = ~ADDR_W'(a); byte_len = LEN_W'(len) ^ 8'h5A | 8'h01;
         @(negedge clk);
         start = 1'b0;
         chk(bus_req == 1'b1, "R3 wait for grant", int'(bus_req), 1);
         chk(int'(burst_addr) == hold_a, "R12 address kept", int'(burst_addr), hold_a);
         chk(int'(burst_words) == hold_w, "R12 count kept", int'(burst_words), hold_w);
         bus_gnt = 1'b1;
         @(negedge clk);
         bus_gnt = 1'b0;
         if (p % 7 == 5 && bn == 0 && !zero_done) begin
            burst_stop = 1'b1;
            @(negedge clk);
            burst_stop = 1'b0;
            zero_done = 1'b1;
            chk(int'(burst_addr) == (ra & ~3), "R7 empty burst no advance",
                int'(burst_addr), ra & ~3);
            continue;
         end
         early = ((p + bn) % 4 == 3) && ebw > 1;
         nsend = early ? ebw - 1 : ebw;
         for (int k = 0; k < nsend; k++) begin
            int eb;
            beat_valid = 1'b1;
            burst_stop = early && (k == nsend - 1);
            abort      = do_abort && (k == 0);
            eb = exp_be((ra & ~3) + 4 * k, a, a + len);
            chk(int'(byte_en) == eb, (k == 0) ? "R5 byte enables" : "R6 byte enables",
                int'(byte_en), eb);
            @(negedge clk);
         end
         beat_valid = 1'b0; burst_stop = 1'b0; abort = 1'b0;
         bytes = nsend * 4 - off;
         if (bytes > rr) bytes = rr;
         ra += bytes; rr -= bytes; bn++;
         if (rr == 0) begin
            chk(done == 1'b1, "R9 done", int'(done), 1);
            chk(bus_req == 1'b0, "R9 request dropped", int'(bus_req), 0);
            @(negedge clk);
            chk(done == 1'b0, "R9 pulse width", int'(done), 0);
            chk(busy == 1'b0, "R9 idle after", int'(busy), 0);
            break;
         end
         if (do_abort) begin
            chk(busy == 1'b0, "R10 idle", int'(busy), 0);
            chk(bus_req == 1'b0, "R10 no request", int'(bus_req), 0);
            chk(done == 1'b0, "R10 no done", int'(done), 0);
            @(negedge clk);
            chk(done == 1'b0, "R10 no done later", int'(done), 0);
            break;
         end
         if (early)
            chk(int'(burst_addr) == (ra & ~3), "R7 resume after early stop",
                int'(burst_addr), ra & ~3);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_req == 1'b0, "R1 bus_req", int'(bus_req), 0);
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(byte_en == 4'h0, "R1 byte_en", int'(byte_en), 0);
      chk(xfer_dir == 1'b1, "R11 direction", int'(xfer_dir), 1);
      rst_n = 1'b1;
      for (int o = 0; o < 4; o++)
         for (int len = 0; len < 20; len++) begin
            int p = o * 20 + len;
            run_pkt(16'h0400 + p * 32 + o, len, p % 6, p, 1'b0);
         end
      run_pkt(16'h3002, 250, 0, 11, 1'b0);   // R11 long packet
      run_pkt(16'h5001, 40, 3, 100, 1'b1);   // R10 abort
      run_pkt(16'h6003, 9, 0, 12, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule